// File: doc/BRIEF.md
# I2S Stereo Receive Channel

This block is the receive side of a serial stereo audio port. It watches a bit-clock strobe that the surrounding logic produces once per rising edge of the serial bit clock. On each strobe it samples the word-select and serial-data lines. It rebuilds the left and right sample words in the standard two-channel audio framing, where the most significant bit of a word arrives one bit clock after word select changes.

Each completed stereo pair is placed right-aligned, at the chosen word length, into a pair FIFO. Software or a mover reads a pair back as a left read followed by a right read. The fill level drives a data-available interrupt through a programmable trigger level. A pair that arrives while the FIFO is full is dropped and raises a sticky overrun flag, which a clear pulse removes. Both interrupt outputs have mask inputs.

Top module: `i2s_rx_channel`

## Requirements
- R1: Serial data is sampled only on cycles where `bit_stb` is high. The bit sampled one strobe after a word-select change is the MSB of the new word. Word select low marks a left word and high marks a right word.
- R2: `len_sel` picks the word length: 1 gives 12 bits, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6, 7 and 0 give 32. The received word lands with its LSB in bit 0, the bits above the length read as zero, and serial bits after the last word bit of a half-frame are ignored.
- R3: Reception starts only at a left half-frame, meaning a high-to-low word-select change, seen while the channel is active (`glb_en`, `blk_en` and `ch_en` all high). A pair is stored when the next left half-frame begins.
- R4: The FIFO holds up to DEPTH pairs in arrival order. `left_data`/`right_data` show the oldest stored pair, and read as zero when the FIFO is empty.
- R5: A pair is removed by an `rd_left` pulse followed by an `rd_right` pulse. An `rd_right` pulse with no `rd_left` before it is ignored.
- R6: When a pair completes while the FIFO is full and no pair is being removed, the new pair is discarded, the stored pairs are unchanged, and the overrun flag is set.
- R7: `ovr_irq` is the overrun flag gated by `mask_ovr` (1 = masked). A pulse on `ovr_clr` clears the flag.
- R8: `avail_irq` is high when `mask_avail` is 0 and the number of stored pairs is at least `trig_lvl` + 1.
- R9: Dropping `glb_en` or `blk_en` empties the FIFO. Dropping only `ch_en` stops reception but keeps the stored pairs.
- R10: A `flush` pulse empties the FIFO while the channel is inactive. While the channel is active, a flush pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per rising bit-clock edge |
| ws_i | input | 1 | Word select (0 left, 1 right) |
| sd_i | input | 1 | Serial data in |
| glb_en | input | 1 | Global enable |
| blk_en | input | 1 | Receiver block enable |
| ch_en | input | 1 | Channel enable |
| len_sel | input | 3 | Word length code |
| trig_lvl | input | 4 | Data-available trigger, level = value + 1 |
| flush | input | 1 | FIFO flush pulse (inactive channel only) |
| rd_left | input | 1 | Left read pulse |
| rd_right | input | 1 | Right read pulse, removes the pair |
| ovr_clr | input | 1 | Overrun flag clear pulse |
| mask_avail | input | 1 | 1 masks the data-available interrupt |
| mask_ovr | input | 1 | 1 masks the overrun interrupt |
| left_data | output | 32 | Left word of the oldest pair |
| right_data | output | 32 | Right word of the oldest pair |
| avail_irq | output | 1 | Data-available interrupt |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The bench sweeps all eight length codes with three bit patterns and pads every half-frame with ones. Residue in the upper bits would then show up, as would a wrong alignment or a left/right swap. It fills the FIFO one pair past its depth to show the drop-newest rule and pair order. At every fill level from full to empty it sweeps all sixteen trigger values. Separate runs start the channel mid-frame, flush while active and while inactive, and disable the channel alone versus the block. These runs separate R3, R9 and R10 from each other.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int unsigned SAMPLE_W = 32;
    localparam int unsigned BITCNT_W = $clog2(SAMPLE_W + 1);

    // Maps the 3-bit length code to a bit count; unknown codes mean full width.
    function automatic logic [BITCNT_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd1:    word_bits = BITCNT_W'(12);
            3'd2:    word_bits = BITCNT_W'(16);
            3'd3:    word_bits = BITCNT_W'(20);
            3'd4:    word_bits = BITCNT_W'(24);
            default: word_bits = BITCNT_W'(SAMPLE_W);
        endcase
    endfunction

endpackage

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic                active,
    input  logic [2:0]          len_sel,
    output logic                push_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o
);

    typedef struct packed {
        logic                ws_now;
        logic                ws_old;
        logic                armed;
        logic                pair_open;
        logic [BITCNT_W-1:0] cnt;
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] left_hold;
        logic                push;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
    } deser_t;

    deser_t st_d, st_q;
    logic [BITCNT_W-1:0] len_bits;
    logic                edge_start;

    assign len_bits   = word_bits(len_sel);
    assign edge_start = (st_q.ws_now != st_q.ws_old);

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        if (bit_stb) begin
            st_d.ws_now = ws_i;
            st_d.ws_old = st_q.ws_now;
            if (edge_start) begin
                if (!st_q.ws_now) begin
                    if (st_q.armed && st_q.pair_open) begin
                        st_d.push  = 1'b1;
                        st_d.out_l = st_q.left_hold;
                        st_d.out_r = st_q.shreg;
                    end
                    st_d.pair_open = 1'b0;
                    st_d.armed     = active;
                end else if (st_q.armed) begin
                    st_d.left_hold = st_q.shreg;
                    st_d.pair_open = 1'b1;
                end
                st_d.shreg = {{(SAMPLE_W-1){1'b0}}, sd_i};
                st_d.cnt   = BITCNT_W'(1);
            end else if (st_q.cnt < len_bits) begin
                st_d.shreg = {st_q.shreg[SAMPLE_W-2:0], sd_i};
                st_d.cnt   = BITCNT_W'(st_q.cnt + BITCNT_W'(1));
            end
        end
        if (!active) begin
            st_d.armed     = 1'b0;
            st_d.pair_open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_o  = st_q.push;
    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;

    // R3
    single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= BITCNT_W'(SAMPLE_W));

endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_l,
    input  logic [DATA_W-1:0] push_r,
    input  logic              rd_left,
    input  logic              rd_right,
    output logic [DATA_W-1:0] head_l,
    output logic [DATA_W-1:0] head_r,
    output logic [CW-1:0]     count_o,
    output logic              drop_o
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          left_seen;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DATA_W-1:0] mem_l [DEPTH];
    logic [DATA_W-1:0] mem_r [DEPTH];
    logic not_empty, full, pop, wr_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + AW'(1));
    endfunction

    assign not_empty = (ctl_q.count != '0);
    assign full      = (ctl_q.count == CW'(DEPTH));
    assign pop       = rd_right && ctl_q.left_seen && not_empty;
    assign wr_ok     = push_i && (!full || pop) && !clear_i;
    assign drop_o    = push_i && full && !pop && !clear_i;

    always_comb begin
        ctl_d = ctl_q;
        if (rd_left && not_empty) ctl_d.left_seen = 1'b1;
        if (pop) begin
            ctl_d.left_seen = 1'b0;
            ctl_d.rd_ptr    = bump(ctl_q.rd_ptr);
        end
        if (wr_ok) ctl_d.wr_ptr = bump(ctl_q.wr_ptr);
        case ({wr_ok, pop})
            2'b10:   ctl_d.count = CW'(ctl_q.count + CW'(1));
            2'b01:   ctl_d.count = CW'(ctl_q.count - CW'(1));
            default: ctl_d.count = ctl_q.count;
        endcase
        if (clear_i) ctl_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_l[ctl_q.wr_ptr] <= push_l;
            mem_r[ctl_q.wr_ptr] <= push_r;
        end
    end

    assign head_l  = not_empty ? mem_l[ctl_q.rd_ptr] : '0;
    assign head_r  = not_empty ? mem_r[ctl_q.rd_ptr] : '0;
    assign count_o = ctl_q.count;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.count <= CW'(DEPTH));

    // R6
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !rd_right && !clear_i) |=> (ctl_q.count == CW'(DEPTH)));

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ctl_q.count == '0));

endmodule

// File: rtl/i2s_rx_channel.sv
module i2s_rx_channel
    import i2s_rx_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned TRIG_W = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned CMP_W = (CW > TRIG_W + 1) ? CW : TRIG_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic                glb_en,
    input  logic                blk_en,
    input  logic                ch_en,
    input  logic [2:0]          len_sel,
    input  logic [TRIG_W-1:0]   trig_lvl,
    input  logic                flush,
    input  logic                rd_left,
    input  logic                rd_right,
    input  logic                ovr_clr,
    input  logic                mask_avail,
    input  logic                mask_ovr,
    output logic [SAMPLE_W-1:0] left_data,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                avail_irq,
    output logic                ovr_irq
);

    typedef struct packed {
        logic ovr;
    } flag_t;

    flag_t flg_d, flg_q;

    logic                active, fifo_clear, push, drop;
    logic [SAMPLE_W-1:0] pair_l, pair_r;
    logic [CW-1:0]       fill;

    assign active     = glb_en && blk_en && ch_en;
    assign fifo_clear = !glb_en || !blk_en || (flush && !active);

    i2s_rx_deser u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .ws_i    (ws_i),
        .sd_i    (sd_i),
        .active  (active),
        .len_sel (len_sel),
        .push_o  (push),
        .left_o  (pair_l),
        .right_o (pair_r)
    );

    i2s_rx_fifo #(
        .DATA_W (SAMPLE_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (fifo_clear),
        .push_i   (push),
        .push_l   (pair_l),
        .push_r   (pair_r),
        .rd_left  (rd_left),
        .rd_right (rd_right),
        .head_l   (left_data),
        .head_r   (right_data),
        .count_o  (fill),
        .drop_o   (drop)
    );

    always_comb begin
        flg_d     = flg_q;
        flg_d.ovr = (flg_q.ovr && !ovr_clr) || drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign avail_irq = !mask_avail &&
        (CMP_W'(fill) >= CMP_W'(trig_lvl) + CMP_W'(1));
    assign ovr_irq   = flg_q.ovr && !mask_ovr;

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> flg_q.ovr);

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !drop) |=> !flg_q.ovr);

endmodule

// File: tb/i2s_rx_channel_tb.sv
module i2s_rx_channel_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
    logic        glb_en = 1'b0, blk_en = 1'b0, ch_en = 1'b0;
    logic [2:0]  len_sel = 3'd5;
    logic [3:0]  trig_lvl = 4'd0;
    logic        flush = 1'b0, rd_left = 1'b0, rd_right = 1'b0, ovr_clr = 1'b0;
    logic        mask_avail = 1'b1, mask_ovr = 1'b1;
    logic [31:0] left_data, right_data;
    logic        avail_irq, ovr_irq;

    int checks = 0;
    int errors = 0;
    logic prev_lsb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_rx_channel dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ws_i(ws_i), .sd_i(sd_i),
        .glb_en(glb_en), .blk_en(blk_en), .ch_en(ch_en), .len_sel(len_sel),
        .trig_lvl(trig_lvl), .flush(flush), .rd_left(rd_left), .rd_right(rd_right),
        .ovr_clr(ovr_clr), .mask_avail(mask_avail), .mask_ovr(mask_ovr),
        .left_data(left_data), .right_data(right_data),
        .avail_irq(avail_irq), .ovr_irq(ovr_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] trim(input logic [31:0] w, input int len);
        return (len == 32) ? w : (w & ((32'h1 << len) - 32'h1));
    endfunction

    task automatic slot(input logic wsv, input logic b);
        @(negedge clk);
        ws_i = wsv; sd_i = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One 32-slot half-frame; bits after the word are padded with ones.
    task automatic half(input logic wsv, input logic [31:0] w, input int len);
        for (int j = 0; j < 32; j++) begin
            logic b;
            if (j == 0)           b = prev_lsb;
            else if (j - 1 < len) b = w[len - j];
            else                  b = 1'b1;
            slot(wsv, b);
        end
        prev_lsb = (len == 32) ? w[0] : 1'b1;
    endtask

    task automatic frame(input logic [31:0] l, input logic [31:0] r, input int len);
        half(1'b0, l, len);
        half(1'b1, r, len);
    endtask

    task automatic close_pair();
        slot(1'b0, prev_lsb);
        slot(1'b0, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic read_pair(input string req, input logic [31:0] el, input logic [31:0] er);
        @(negedge clk);
        chk(req, left_data, el);
        chk(req, right_data, er);
        rd_left = 1'b1;
        @(negedge clk);
        rd_left = 1'b0; rd_right = 1'b1;
        @(negedge clk);
        rd_right = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state: empty FIFO reads zero, no interrupts
        chk("R4 reset left", left_data, 32'h0);
        chk("R4 reset right", right_data, 32'h0);
        mask_avail = 1'b0; mask_ovr = 1'b0;
        @(negedge clk);
        chk("R8 reset avail", {31'b0, avail_irq}, 32'h0);
        chk("R7 reset ovr", {31'b0, ovr_irq}, 32'h0);

        glb_en = 1'b1; blk_en = 1'b1;

        // R1 R2 length sweep over all codes and three patterns
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < 3; p++) begin
                logic [31:0] l, r;
                int len;
                len = len_of(3'(code));
                l = (p == 0) ? 32'hDEADBEEF : (p == 1) ? 32'h80000801 : 32'h5A5AA5A5 ^ 32'(code);
                r = ~l ^ 32'(p);
                len_sel = 3'(code);
                ch_en = 1'b1;
                half(1'b1, 32'h0, len);
                frame(l, r, len);
                close_pair();
                ch_en = 1'b0;
                read_pair("R1 R2 sweep", trim(l, len), trim(r, len));
                chk("R2 empty after sweep read", left_data, 32'h0);
            end
        end

        // R6 fill one past depth, newest pair dropped
        len_sel = 3'd5;
        ch_en = 1'b1;
        half(1'b1, 32'h0, 32);
        for (int i = 0; i < 17; i++)
            frame(32'hC0DE0000 | 32'(i), 32'h0BAD0000 | 32'(i * 3), 32);
        close_pair();
        ch_en = 1'b0;
        @(negedge clk);
        chk("R6 overrun irq", {31'b0, ovr_irq}, 32'h1);
        mask_ovr = 1'b1; #1;
        chk("R7 ovr masked", {31'b0, ovr_irq}, 32'h0);
        mask_ovr = 1'b0;
        mask_avail = 1'b1; trig_lvl = 4'd0; #1;
        chk("R8 avail masked", {31'b0, avail_irq}, 32'h0);
        mask_avail = 1'b0;
        pulse(ovr_clr);
        chk("R7 ovr cleared", {31'b0, ovr_irq}, 32'h0);

        // R5 right read without left is ignored
        pulse(rd_right);
        chk("R5 lone right ignored", left_data, 32'hC0DE0000);

        // R4 R8 drain, sweeping trigger levels at every fill level
        for (int c = 16; c >= 0; c--) begin
            for (int t = 0; t < 16; t++) begin
                @(negedge clk);
                trig_lvl = 4'(t); #1;
                chk("R8 trigger", {31'b0, avail_irq}, {31'b0, (c >= t + 1)});
            end
            if (c > 0)
                read_pair("R4 R6 order", 32'hC0DE0000 | 32'(16 - c), 32'h0BAD0000 | 32'((16 - c) * 3));
        end
        chk("R6 dropped pair absent", right_data, 32'h0);

        // R3 enable mid-frame: only the next full frame is taken
        half(1'b1, 32'h0, 32);
        half(1'b0, 32'h11111111, 32);
        ch_en = 1'b1;
        half(1'b1, 32'h22222222, 32);
        frame(32'h33333333, 32'h44444444, 32);
        close_pair();
        ch_en = 1'b0;
        read_pair("R3 start at left", 32'h33333333, 32'h44444444);
        chk("R3 nothing else stored", left_data, 32'h0);

        // R10 flush while active has no effect, inactive flush empties
        ch_en = 1'b1;
        half(1'b1, 32'h0, 32);
        frame(32'hAAAA0001, 32'hBBBB0001, 32);
        frame(32'hAAAA0002, 32'hBBBB0002, 32);
        close_pair();
        pulse(flush);
        chk("R10 active flush ignored", left_data, 32'hAAAA0001);
        ch_en = 1'b0;
        @(negedge clk);
        chk("R9 channel-only disable keeps data", left_data, 32'hAAAA0001);
        pulse(flush);
        chk("R10 inactive flush empties", left_data, 32'h0);
        trig_lvl = 4'd0; #1;
        chk("R10 avail after flush", {31'b0, avail_irq}, 32'h0);

        // R9 block disable empties
        ch_en = 1'b1;
        half(1'b1, 32'h0, 32);
        frame(32'h12345678, 32'h9ABCDEF0, 32);
        close_pair();
        chk("R9 stored before disable", left_data, 32'h12345678);
        blk_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 block disable empties", left_data, 32'h0);
        chk("R9 block disable right", right_data, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule